// File: doc/BRIEF.md
# Shift, Rotate and Nybble-Permute Unit

This block runs the shift group of a stack machine's execution stage on one stack cell. A `start` pulse hands it an opcode byte, the operand value (the second stack cell), a count or index word (the top stack cell) and the current carry flag. It returns the new cell value, the new carry and a flag that marks an opcode outside the group. The value can be shifted logically or arithmetically, rotated inside the cell, or rotated through a ring that includes the carry. A nybble permutation steers every 4-bit group of the value to a destination slot given by the index word, which makes byte-order swaps cheap.

The unit iterates over several cycles. A controller with four states sequences the work. `S_IDLE` waits for `start`. `S_SHIFT` applies one single-bit step per cycle. `S_PERM` deposits one source nybble per cycle. `S_DONE` raises `done` for one cycle. The transitions are as follows. `S_IDLE` goes to `S_DONE` on an illegal opcode or a zero effective count. It goes to `S_PERM` on a permute, and to `S_SHIFT` otherwise. `S_SHIFT` goes to `S_DONE` after the last step. `S_PERM` goes to `S_DONE` after the last nybble. `S_DONE` always returns to `S_IDLE`. The result registers keep their value from one `done` until the next accepted `start`. The cell width is a parameter, a power of two from 16 to 64, with a default of 64.

Top module: `shr_unit`

## Requirements
- R1: `start` is accepted only in the idle state. `busy` is high while steps or nybbles are being processed. `done` is high for exactly one cycle. A `start` raised while the unit is busy is ignored and produces no extra `done`. `result`, `carry_out` and `illegal` hold their value after `done` until the next accepted `start`.
- R2: An opcode is legal only when bits 3:0 are 1011 and bit 7 is 0. Bits 6:4 select the function: 0 LSL, 1 LSR, 2 ASR, 3 PERMUTE, 4 RL, 5 RLC, 6 RR, 7 RRC. Any other opcode gives `illegal`=1, returns the operand unchanged in `result`, and returns `carry_in` in `carry_out`.
- R3: LSL moves the value left by the count and fills the vacated bits with zeros. The carry receives the last bit shifted out.
- R4: LSR moves the value right by the count and fills the vacated top bits with zeros. The carry receives the last bit shifted out of bit 0.
- R5: ASR moves the value right by the count and fills the vacated top bits with copies of the sign bit. The carry receives the last bit shifted out of bit 0.
- R6: A shift count of WIDTH or more gives the fully shifted value: all zeros, or all sign bits for ASR. For a count of exactly WIDTH, the carry is the last bit that leaves the cell. For a larger count, the carry is 0, or the sign bit for ASR.
- R7: RL and RR rotate inside the cell by the count modulo WIDTH and leave the carry unchanged.
- R8: RLC and RRC rotate a ring of WIDTH+1 bits, made of the carry above the cell's top bit, by the count modulo WIDTH. The carry comes out of the ring.
- R9: An effective count of zero leaves both the value and the carry unchanged. This covers a zero count for any shift or rotate, and a count that is a multiple of WIDTH for a rotate.
- R10: For PERMUTE, source nybble k of the operand is placed at the destination nybble numbered by the low log2(WIDTH/4) bits of nybble k of the index word. Sources that meet at one destination are ORed together. A destination that receives no source is zero. The carry is unchanged.
- R11: `done` rises a fixed number of cycles after the edge that accepts `start`. The delay is 1 cycle for an illegal opcode or a zero effective count, s+1 cycles for s effective single-bit steps (with s capped at WIDTH+1 for shifts), and WIDTH/4+1 cycles for PERMUTE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled in the idle state) |
| opcode | input | 8 | Instruction byte of the shift group |
| n_in | input | WIDTH | Operand value (second stack cell) |
| cnt_in | input | WIDTH | Shift count or permute index word (top stack cell) |
| carry_in | input | 1 | Carry flag before the operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | WIDTH | Result cell |
| carry_out | output | 1 | Carry flag after the operation |
| illegal | output | 1 | Opcode is outside the legal shift group |

## Verification
The bench targets the count boundaries. These are counts of exactly WIDTH, WIDTH+1 and far beyond it for shifts, and a count of zero and multiples of WIDTH for rotates. A design that clamped the count wrongly would return a stale carry or a partly shifted value, and a design that did not reduce rotate counts modulo WIDTH would spin for the wrong number of steps and miss the expected latency. Rotates run with the carry both set and clear. This exposes a design that leaks the carry into RL/RR, or that leaves the carry out of the RLC/RRC ring. Permutations cover the identity index, a byte reversal and a case where every source lands on one destination, so a design that overwrites a destination instead of ORing into it, or that leaves stale bits in unused slots, would fail. A `start` poked while the unit is busy must give no second completion and must not corrupt the result.

// File: rtl/shr_pkg.sv
package shr_pkg;

    typedef enum logic [2:0] {
        OP_LSL  = 3'd0,
        OP_LSR  = 3'd1,
        OP_ASR  = 3'd2,
        OP_PERM = 3'd3,
        OP_RL   = 3'd4,
        OP_RLC  = 3'd5,
        OP_RR   = 3'd6,
        OP_RRC  = 3'd7
    } shr_op_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SHIFT = 2'd1,
        S_PERM  = 2'd2,
        S_DONE  = 2'd3
    } shr_state_e;

    // low nibble that marks the shift group
    localparam logic [3:0] GROUP_TAG = 4'b1011;

endpackage

// File: rtl/shr_decode.sv
module shr_decode
    import shr_pkg::*;
(
    input  logic [7:0] opcode,
    output shr_op_e    op,
    output logic       bad_op,
    output logic       is_perm,
    output logic       is_rot
);
    always_comb begin
        op      = shr_op_e'(opcode[6:4]);
        // R2: bit 7 set, or a foreign low nibble, is outside the group
        bad_op  = opcode[7] | (opcode[3:0] != GROUP_TAG);
        is_perm = (op == OP_PERM);
        is_rot  = opcode[6];
    end
endmodule

// File: rtl/shr_step.sv
module shr_step
    import shr_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  shr_op_e          op,
    input  logic [WIDTH-1:0] d_in,
    input  logic             c_in,
    output logic [WIDTH-1:0] d_out,
    output logic             c_out
);
    // one single-bit move of the selected operation
    always_comb begin
        d_out = d_in;
        c_out = c_in;
        unique case (op)
            OP_LSL: begin
                d_out = {d_in[WIDTH-2:0], 1'b0};
                c_out = d_in[WIDTH-1];
            end
            OP_LSR: begin
                d_out = {1'b0, d_in[WIDTH-1:1]};
                c_out = d_in[0];
            end
            OP_ASR: begin
                d_out = {d_in[WIDTH-1], d_in[WIDTH-1:1]};
                c_out = d_in[0];
            end
            OP_RL: begin
                d_out = {d_in[WIDTH-2:0], d_in[WIDTH-1]};
            end
            OP_RR: begin
                d_out = {d_in[0], d_in[WIDTH-1:1]};
            end
            OP_RLC: begin
                d_out = {d_in[WIDTH-2:0], c_in};
                c_out = d_in[WIDTH-1];
            end
            OP_RRC: begin
                d_out = {c_in, d_in[WIDTH-1:1]};
                c_out = d_in[0];
            end
            OP_PERM: begin
                d_out = d_in;
                c_out = c_in;
            end
        endcase
    end
endmodule

// File: rtl/shr_nyb_place.sv
module shr_nyb_place #(
    parameter int WIDTH = 64,
    localparam int NYB  = WIDTH / 4,
    localparam int SELW = $clog2(NYB)
) (
    input  logic [3:0]       nyb,
    input  logic [SELW-1:0]  sel,
    output logic [WIDTH-1:0] placed
);
    // one decoder slot per destination nybble
    for (genvar j = 0; j < NYB; j++) begin : g_slot
        assign placed[4*j +: 4] = (sel == SELW'(j)) ? nyb : 4'b0000;
    end
endmodule

// File: rtl/shr_unit.sv
module shr_unit
    import shr_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       opcode,
    input  logic [WIDTH-1:0] n_in,
    input  logic [WIDTH-1:0] cnt_in,
    input  logic             carry_in,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             illegal
);
    localparam int NYB     = WIDTH / 4;
    localparam int SELW    = $clog2(NYB);
    localparam int LOG_W   = $clog2(WIDTH);
    localparam int CNT_MAX = WIDTH + 1;
    localparam int STEP_W  = $clog2(WIDTH + 2);
    localparam int LANE_W  = $clog2(NYB);

    shr_state_e         state_q, state_d;
    shr_op_e            op_q;
    logic [WIDTH-1:0]   data_q;
    logic               carry_q;
    logic               illegal_q;
    logic [WIDTH-1:0]   src_q;
    logic [WIDTH-1:0]   idx_q;
    logic [STEP_W-1:0]  steps_q;
    logic [LANE_W-1:0]  lanes_q;

    shr_op_e            dec_op;
    logic               dec_bad;
    logic               dec_perm;
    logic               dec_rot;
    logic [STEP_W-1:0]  start_steps;
    logic [WIDTH-1:0]   step_data;
    logic               step_carry;
    logic [WIDTH-1:0]   placed;

    shr_decode u_decode (
        .opcode  (opcode),
        .op      (dec_op),
        .bad_op  (dec_bad),
        .is_perm (dec_perm),
        .is_rot  (dec_rot)
    );

    shr_step #(.WIDTH(WIDTH)) u_step (
        .op    (op_q),
        .d_in  (data_q),
        .c_in  (carry_q),
        .d_out (step_data),
        .c_out (step_carry)
    );

    shr_nyb_place #(.WIDTH(WIDTH)) u_place (
        .nyb    (src_q[3:0]),
        .sel    (idx_q[SELW-1:0]),
        .placed (placed)
    );

    // effective step count: rotates wrap, shifts saturate one past the cell
    always_comb begin
        if (dec_rot) begin
            start_steps = STEP_W'(cnt_in[LOG_W-1:0]);
        end else if (cnt_in > WIDTH'(CNT_MAX)) begin
            start_steps = STEP_W'(CNT_MAX);
        end else begin
            start_steps = cnt_in[STEP_W-1:0];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    if (dec_bad) begin
                        state_d = S_DONE;
                    end else if (dec_perm) begin
                        state_d = S_PERM;
                    end else if (start_steps == '0) begin
                        state_d = S_DONE;
                    end else begin
                        state_d = S_SHIFT;
                    end
                end
            end
            S_SHIFT: begin
                if (steps_q == STEP_W'(1)) begin
                    state_d = S_DONE;
                end
            end
            S_PERM: begin
                if (lanes_q == LANE_W'(NYB - 1)) begin
                    state_d = S_DONE;
                end
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= OP_LSL;
            data_q    <= '0;
            carry_q   <= 1'b0;
            illegal_q <= 1'b0;
            src_q     <= '0;
            idx_q     <= '0;
            steps_q   <= '0;
            lanes_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        op_q      <= dec_op;
                        data_q    <= (dec_perm && !dec_bad) ? '0 : n_in;
                        carry_q   <= carry_in;
                        illegal_q <= dec_bad;
                        src_q     <= n_in;
                        idx_q     <= cnt_in;
                        steps_q   <= start_steps;
                        lanes_q   <= '0;
                    end
                end
                S_SHIFT: begin
                    data_q  <= step_data;
                    carry_q <= step_carry;
                    steps_q <= steps_q - STEP_W'(1);
                end
                S_PERM: begin
                    data_q  <= data_q | placed;
                    src_q   <= src_q >> 4;
                    idx_q   <= idx_q >> 4;
                    lanes_q <= lanes_q + LANE_W'(1);
                end
                S_DONE: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q == S_SHIFT) || (state_q == S_PERM);
        done      = (state_q == S_DONE);
        result    = data_q;
        carry_out = carry_q;
        illegal   = illegal_q;
    end

    // R1: completion is a single-cycle pulse
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: never busy and done together
    p_busy_done_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R2: an opcode with bit 7 set completes at once as illegal
    p_illegal_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start && opcode[7]) |=> (done && illegal));

    // R7: in-cell rotate steps never touch the carry
    p_rot_keeps_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SHIFT && (op_q == OP_RL || op_q == OP_RR)) |=> $stable(carry_out));

    // R10: nybble deposit never touches the carry
    p_perm_keeps_carry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PERM) |=> $stable(carry_out));

    // R6: a step loop never exceeds the saturated shift length
    p_step_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SHIFT) |-> (steps_q != '0 && steps_q <= STEP_W'(CNT_MAX)));

endmodule

// File: tb/test_shr_unit.sv
`timescale 1ns/1ps
module test_shr_unit;
    localparam int W   = 64;
    localparam int NYB = W / 4;

    typedef struct packed {
        logic [W-1:0] res;
        logic         cy;
        logic         ill;
        logic [31:0]  lat;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [7:0]   opcode = 8'h00;
    logic [W-1:0] n_in = '0;
    logic [W-1:0] cnt_in = '0;
    logic         carry_in = 1'b0;
    logic         busy, done, carry_out, illegal;
    logic [W-1:0] result;

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    int    start_cyc = 0;
    bit    finished = 0;
    exp_t  exp_q[$];
    string req_q[$];
    exp_t  last_exp;

    shr_unit #(.WIDTH(W)) i_shr_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .n_in(n_in), .cnt_in(cnt_in), .carry_in(carry_in),
        .busy(busy), .done(done), .result(result),
        .carry_out(carry_out), .illegal(illegal)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // reference model written from the requirements
    function automatic exp_t model(input logic [7:0] opc, input logic [W-1:0] n,
                                   input logic [W-1:0] cnt, input logic c);
        exp_t e;
        int s;
        logic [2*W+1:0] v;
        logic signed [2*W+1:0] sv;
        logic [2*W-1:0] d2;
        logic [W:0] ring;
        logic [2*W+1:0] r2;
        e.res = n; e.cy = c; e.ill = 1'b0; e.lat = 1;
        if (opc[7] || opc[3:0] != 4'hB) begin
            e.ill = 1'b1;
            return e;
        end
        if (opc[6:4] == 3'd3) begin
            e.res = '0;
            for (int k = 0; k < NYB; k++)
                e.res = e.res | (W'(n[4*k +: 4]) << (4 * int'(cnt[4*k +: 4])));
            e.lat = NYB + 1;
            return e;
        end
        if (opc[6]) s = int'(cnt % W);
        else s = (cnt > W + 1) ? W + 1 : int'(cnt);
        e.lat = s + 1;
        if (s == 0) return e;
        ring = {c, n};
        case (opc[6:4])
            3'd0: begin v = (2*W+2)'(n) << s; e.res = v[W-1:0]; e.cy = v[W]; end
            3'd1: begin v = {n, (W+2)'(0)} >> s; e.res = v[2*W+1:W+2]; e.cy = v[W+1]; end
            3'd2: begin sv = {n, (W+2)'(0)}; sv = sv >>> s; e.res = sv[2*W+1:W+2]; e.cy = sv[W+1]; end
            3'd4: begin d2 = {n, n} << s; e.res = d2[2*W-1:W]; end
            3'd6: begin d2 = {n, n} >> s; e.res = d2[W-1:0]; end
            3'd5: begin r2 = {ring, ring} << s; e.res = r2[2*W:W+1]; e.cy = r2[2*W+1]; end
            default: begin r2 = {ring, ring} >> s; e.res = r2[W-1:0]; e.cy = r2[W]; end
        endcase
        return e;
    endfunction

    task automatic wait_empty();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 500) check(1'b0, "R11", "completion timeout", '0, '0);
        @(negedge clk);
    endtask

    // driver: push expectation, pulse start; optional poke while busy
    task automatic run(input logic [7:0] opc, input logic [W-1:0] n,
                       input logic [W-1:0] cnt, input logic c, input string req,
                       input bit poke);
        exp_t e;
        e = model(opc, n, cnt, c);
        exp_q.push_back(e);
        req_q.push_back(req);
        last_exp = e;
        @(negedge clk);
        opcode = opc; n_in = n; cnt_in = cnt; carry_in = c; start = 1'b1;
        start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            // R1: this start arrives while busy and must be ignored
            opcode = 8'h0B; n_in = '1; cnt_in = 1; carry_in = ~c; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_empty();
    endtask

    // monitor: pop and compare at each completion
    always @(negedge clk) begin
        if (rst_n && done && !finished) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1", "unexpected done", W'(done), '0);
            end else begin
                exp_t e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(result === e.res, r, "result", result, e.res);
                check(carry_out === e.cy, r, "carry", W'(carry_out), W'(e.cy));
                check(illegal === e.ill, "R2", "illegal flag", W'(illegal), W'(e.ill));
                check((cyc - start_cyc) == int'(e.lat), "R11", "latency",
                      W'(cyc - start_cyc), W'(e.lat));
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
    end

    localparam logic [W-1:0] NEG88 = 64'hFFFF_FFFF_FFFF_FF88;
    localparam logic [W-1:0] PAT   = 64'h8123_4567_89AB_CDEF;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy === 1'b0 && done === 1'b0, "R1", "reset handshake", W'({busy, done}), '0);
        check(result === '0 && carry_out === 1'b0 && illegal === 1'b0, "R1", "reset outputs",
              result, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run(8'h0B, NEG88, 1, 1'b0, "R3", 0);      // LSL: carry 1
        run(8'h0B, PAT, 12, 1'b0, "R3", 0);
        run(8'h1B, NEG88, 1, 1'b1, "R4", 0);      // LSR: carry 0
        run(8'h1B, PAT, 7, 1'b0, "R4", 0);
        run(8'h2B, NEG88, 1, 1'b1, "R5", 0);      // ASR: sign fill
        run(8'h2B, NEG88, 4, 1'b0, "R5", 0);
        run(8'h2B, 64'h4000_0000_0000_0003, 2, 1'b0, "R5", 0);
        run(8'h0B, PAT, 64, 1'b0, "R6", 0);       // R6: exactly WIDTH
        run(8'h0B, PAT, 65, 1'b1, "R6", 0);
        run(8'h1B, PAT, 1000, 1'b1, "R6", 0);
        run(8'h1B, 64'h1, 64, 1'b0, "R6", 0);
        run(8'h2B, PAT, 70, 1'b0, "R6", 0);
        run(8'h2B, 64'h7FFF_0000_0000_0001, 64, 1'b0, "R6", 0);
        run(8'h4B, PAT, 4, 1'b1, "R7", 0);        // RL
        run(8'h6B, PAT, 8, 1'b0, "R7", 0);        // RR
        run(8'h4B, PAT, 67, 1'b1, "R7", 0);       // modulo WIDTH
        run(8'h5B, NEG88, 1, 1'b0, "R8", 0);      // RLC
        run(8'h7B, PAT, 1, 1'b1, "R8", 0);        // RRC
        run(8'h7B, PAT, 33, 1'b0, "R8", 0);
        run(8'h5B, PAT, 63, 1'b1, "R8", 0);
        run(8'h0B, PAT, 0, 1'b1, "R9", 0);        // zero counts
        run(8'h2B, NEG88, 0, 1'b0, "R9", 0);
        run(8'h5B, PAT, 64, 1'b1, "R9", 0);
        run(8'h6B, PAT, 128, 1'b0, "R9", 0);
        run(8'h3B, PAT, 64'hFEDC_BA98_7654_3210, 1'b1, "R10", 0);  // identity
        run(8'h3B, PAT, 64'h1032_5476_98BA_DCFE, 1'b0, "R10", 0);  // byte reverse
        run(8'h3B, PAT, 64'h0, 1'b1, "R10", 0);                    // all collide
        run(8'h3B, 64'h0000_0000_0000_0F0F, 64'h0000_0000_0000_5533, 1'b0, "R10", 0);
        run(8'h8B, PAT, 3, 1'b1, "R2", 0);        // illegal opcodes
        run(8'hFB, NEG88, 9, 1'b0, "R2", 0);
        run(8'h0A, PAT, 2, 1'b1, "R2", 0);
        run(8'h5B, PAT, 1000, 1'b1, "R1", 1);     // start poked while busy
        repeat (4) @(negedge clk);
        // R1: result held after completion
        check(result === last_exp.res && carry_out === last_exp.cy && done === 1'b0,
              "R1", "held result", result, last_exp.res);

        for (int i = 0; i < 40; i++) begin
            logic [7:0] opc;
            opc = {1'b0, 3'($urandom_range(0, 7)), 4'hB};
            run(opc, {$urandom, $urandom}, (opc[6:4] == 3'd3) ? {$urandom, $urandom}
                : W'($urandom_range(0, 80)), 1'($urandom_range(0, 1)), "R3", 0);
        end
        summary();
    end
endmodule